// File: doc/BRIEF.md
# Pipelined zero-turnaround synchronous SRAM

A single-port synchronous memory whose inputs and outputs are both registered. Reads and writes may be issued on every clock cycle in any order, with no idle cycles between them. To keep the shared data bus busy in both directions, write data is taken from the bus two enabled cycles after its write command, which is the same cycle in which read data would appear. Addresses and controls wait in a two-stage pipeline until their data phase. A captured write is committed to the array one enabled cycle later. Reads that hit that pending write receive the newer bytes.

Each data word is split into 9-bit byte lanes, and each lane has its own active-low write select. Three chip enables must all be active for a command to be accepted. A clock enable freezes the entire block. A two-bit burst sequencer can continue the previous command at the next address, in either linear or interleaved order. An output enable and the block's own read-valid state together form a drive-enable output for an external tristate pad.

Top module: `ztsram_core`

## Requirements
- R1: A read command accepted at enabled rising edge E0 puts the word on `rdata` and raises `rdata_oe` right after the second enabled rising edge following E0. The output stays there until the next enabled edge.
- R2: For a write command accepted at enabled edge E0, `wdata` is sampled at the second enabled edge after E0. A later read of that address returns the sampled word.
- R3: Byte lane i is `wdata`/`rdata` bits [9i+8:9i]. A write updates lane i only when `byte_wr_n[i]` is 0 in the command cycle. All other lanes keep their contents.
- R4: Reads and writes to any addresses may be issued on consecutive cycles in any mix, with no idle cycles, and every result follows R1 and R2.
- R5: A read whose data phase falls in the cycle before a pending write to the same address is committed returns the pending write's selected lanes merged with the stored lanes.
- R6: While `clk_en` is 0, no input is sampled. The pipeline, burst state, `rdata` and the array are unchanged, and every latency counts only enabled edges.
- R7: A load cycle (`adv_ld`=0) with `sel_a_n`=1, `sel_b`=0 or `sel_c_n`=1 is a deselect. The array is not changed and `rdata_oe` stays 0 in its data phase.
- R8: `rdata_oe` is 0 in the data phase of a write, and is 0 at any time that `out_en_n` is 1, without waiting for a clock.
- R9: With `adv_ld`=1 the previous loaded command (read, write or deselect) is repeated. The upper address bits are kept, and step n of the burst uses low bits (start + n) mod 4 when linear. In this cycle `addr`, `wr_n` and the chip enables are ignored, while `byte_wr_n` is taken fresh.
- R10: In interleaved order, step n of a burst uses low address bits start XOR n.
- R11: The burst order (`burst_ilv`: 1 = interleaved, 0 = linear) is taken only at the load cycle. Changing it during advance cycles has no effect.
- R12: A synchronous reset (`rst`=1 at a rising edge) cancels all commands in flight, including writes whose data has not been sampled, and leaves `rdata_oe` at 0. The array contents survive reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset of the control pipeline, active high |
| clk_en | input | 1 | Clock enable; 0 freezes the whole block |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b | input | 1 | Chip enable, active high |
| sel_c_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | 1 = advance the burst, 0 = load a new command |
| wr_n | input | 1 | 0 = write, 1 = read (load cycles only) |
| byte_wr_n | input | DATA_W/9 | Per-lane write select, active low |
| burst_ilv | input | 1 | Burst order taken at load: 1 interleaved, 0 linear |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data, sampled in the data phase |
| rdata | output | DATA_W | Registered read data |
| rdata_oe | output | 1 | Drive enable for the data pads |

## Verification
The assertions check the clocked invariants on every cycle: `rdata` and the burst step counter hold through a stall, the counter steps by one on each advance and clears on each load, the drive enable stays off whenever the output enable is high, and nothing is driven right after reset. Only the bench's scenarios can show the end-to-end data results. These are the two-cycle latency counted across stalls, lane masking, merging of a pending write into a read, burst address orders with inputs that should be ignored, deselects leaving the array alone, and a write cancelled by reset.

// File: rtl/ztsram_pkg.sv
package ztsram_pkg;

    localparam int LANE_W = 9;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // low two address bits for step 'step' of a burst starting at 'start'
    function automatic logic [1:0] burst_lsb(input logic [1:0] start,
                                             input logic [1:0] step,
                                             input logic       ilv);
        return ilv ? (start ^ step) : (start + step);
    endfunction

endpackage

// File: rtl/ztsram_burst.sv
module ztsram_burst
    import ztsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ilv_in,
    input  logic [ADDR_W-1:0] base_q,
    input  logic [1:0]        cnt_q,
    input  logic              ilv_q,
    output logic [ADDR_W-1:0] issue_addr,
    output logic [ADDR_W-1:0] base_d,
    output logic [1:0]        cnt_d,
    output logic              ilv_d
);

    always_comb begin
        if (load) begin
            base_d     = addr_in;
            cnt_d      = 2'd0;
            ilv_d      = ilv_in;
            issue_addr = addr_in;
        end else begin
            base_d     = base_q;
            cnt_d      = cnt_q + 2'd1;
            ilv_d      = ilv_q;
            issue_addr = {base_q[ADDR_W-1:2], burst_lsb(base_q[1:0], cnt_d, ilv_q)};
        end
    end

endmodule

// File: rtl/ztsram_array.sv
module ztsram_array
    import ztsram_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 6
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [DATA_W/LANE_W-1:0] wlanes,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [ADDR_W-1:0]        raddr,
    output logic [DATA_W-1:0]        rdata
);

    localparam int LANES = DATA_W / LANE_W;
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wlanes[g]) begin
                mem[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end

endmodule

// File: rtl/ztsram_merge.sv
module ztsram_merge
    import ztsram_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic [DATA_W-1:0]        stored,
    input  logic [DATA_W-1:0]        pending,
    input  logic [DATA_W/LANE_W-1:0] lanes,
    input  logic                     hit,
    output logic [DATA_W-1:0]        merged
);

    localparam int LANES = DATA_W / LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*LANE_W +: LANE_W] = (hit && lanes[g]) ?
                                            pending[g*LANE_W +: LANE_W] :
                                            stored[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/ztsram_core.sv
module ztsram_core
    import ztsram_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clk_en,
    input  logic                     sel_a_n,
    input  logic                     sel_b,
    input  logic                     sel_c_n,
    input  logic                     adv_ld,
    input  logic                     wr_n,
    input  logic [DATA_W/LANE_W-1:0] byte_wr_n,
    input  logic                     burst_ilv,
    input  logic                     out_en_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    output logic                     rdata_oe
);

    localparam int LANES = DATA_W / LANE_W;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  lanes;
    } stage_t;

    typedef struct packed {
        stage_t            s1;        // command just captured
        stage_t            s2;        // command one cycle before its data phase
        logic              wb_vld;    // captured write waiting for commit
        logic [ADDR_W-1:0] wb_addr;
        logic [LANES-1:0]  wb_lanes;
        logic [DATA_W-1:0] wb_data;
        logic              rd_vld;    // output register holds read data
        logic [DATA_W-1:0] rd_data;
        op_e               b_op;      // command repeated by advance cycles
        logic [ADDR_W-1:0] b_base;
        logic [1:0]        b_cnt;
        logic              b_ilv;
    } state_t;

    state_t st_d, st_q;

    logic              sel_ok;
    op_e               ld_op;
    logic [ADDR_W-1:0] issue_addr;
    logic [ADDR_W-1:0] base_d;
    logic [1:0]        cnt_d;
    logic              ilv_d;
    logic              arr_we;
    logic [DATA_W-1:0] arr_rdata;
    logic              fwd_hit;
    logic [DATA_W-1:0] rd_merged;
    logic [1:0]        burst_step_q;

    assign sel_ok = !sel_a_n && sel_b && !sel_c_n;
    assign ld_op  = !sel_ok ? OP_NONE : (wr_n ? OP_READ : OP_WRITE);

    ztsram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .load       (!adv_ld),
        .addr_in    (addr),
        .ilv_in     (burst_ilv),
        .base_q     (st_q.b_base),
        .cnt_q      (st_q.b_cnt),
        .ilv_q      (st_q.b_ilv),
        .issue_addr (issue_addr),
        .base_d     (base_d),
        .cnt_d      (cnt_d),
        .ilv_d      (ilv_d)
    );

    // commit of the captured write, one enabled edge after its capture
    assign arr_we = clk_en && !rst && st_q.wb_vld;

    ztsram_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
        .clk    (clk),
        .we     (arr_we),
        .waddr  (st_q.wb_addr),
        .wlanes (st_q.wb_lanes),
        .wdata  (st_q.wb_data),
        .raddr  (st_q.s2.addr),
        .rdata  (arr_rdata)
    );

    assign fwd_hit = st_q.wb_vld && (st_q.wb_addr == st_q.s2.addr);

    ztsram_merge #(.DATA_W(DATA_W)) u_merge (
        .stored  (arr_rdata),
        .pending (st_q.wb_data),
        .lanes   (st_q.wb_lanes),
        .hit     (fwd_hit),
        .merged  (rd_merged)
    );

    always_comb begin
        st_d = st_q;
        if (clk_en) begin
            // command stage
            if (adv_ld) begin
                st_d.s1.op = st_q.b_op;
            end else begin
                st_d.s1.op = ld_op;
                st_d.b_op  = ld_op;
            end
            st_d.s1.addr  = issue_addr;
            st_d.s1.lanes = ~byte_wr_n;
            st_d.b_base   = base_d;
            st_d.b_cnt    = cnt_d;
            st_d.b_ilv    = ilv_d;

            // middle stage
            st_d.s2 = st_q.s1;

            // data phase of the command in s2
            st_d.wb_vld   = (st_q.s2.op == OP_WRITE);
            st_d.wb_addr  = st_q.s2.addr;
            st_d.wb_lanes = st_q.s2.lanes;
            st_d.wb_data  = wdata;
            st_d.rd_vld   = (st_q.s2.op == OP_READ);
            if (st_q.s2.op == OP_READ) begin
                st_d.rd_data = rd_merged;
            end
        end
        if (rst) begin
            st_d.s1.op  = OP_NONE;
            st_d.s2.op  = OP_NONE;
            st_d.b_op   = OP_NONE;
            st_d.b_cnt  = 2'd0;
            st_d.wb_vld = 1'b0;
            st_d.rd_vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rdata        = st_q.rd_data;
    assign rdata_oe     = st_q.rd_vld && !out_en_n;
    assign burst_step_q = st_q.b_cnt;

endmodule

// File: rtl/ztsram_core_chk.sv
module ztsram_core_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst,
    input logic              clk_en,
    input logic              adv_ld,
    input logic              out_en_n,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_oe,
    input logic [1:0]        burst_step
);

    logic rst_seen_q = 1'b0;

    always_ff @(posedge clk) begin
        if (rst_seen_q) begin
            assert_idle_after_reset_R12: assert (!rdata_oe)
                else $error("drive enable high right after reset");
        end
        rst_seen_q <= rst;
    end

    assert_hold_data_R6: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(rdata));

    assert_hold_step_R6: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(burst_step));

    assert_data_on_enabled_edge_R1: assert property (@(posedge clk) disable iff (rst)
        !$stable(rdata) |-> $past(clk_en));

    assert_oe_gated_R8: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> !rdata_oe);

    assert_step_advance_R9: assert property (@(posedge clk) disable iff (rst)
        (clk_en && adv_ld) |=> (burst_step == $past(burst_step) + 2'd1));

    assert_step_load_R9: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !adv_ld) |=> (burst_step == 2'd0));

endmodule

bind ztsram_core ztsram_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clk_en     (clk_en),
    .adv_ld     (adv_ld),
    .out_en_n   (out_en_n),
    .rdata      (rdata),
    .rdata_oe   (rdata_oe),
    .burst_step (burst_step_q)
);

// File: tb/ztsram_core_tb.sv
`timescale 1ns/1ps
module ztsram_core_tb;

    localparam int K_DES = 0;
    localparam int K_RD  = 1;
    localparam int K_WR  = 2;
    localparam int K_ADV = 3;

    localparam logic [35:0] D5  = {9'h011, 9'h022, 9'h033, 9'h044};
    localparam logic [35:0] D6  = {9'h155, 9'h166, 9'h177, 9'h188};
    localparam logic [35:0] PW  = {9'h0AA, 9'h0BB, 9'h0CC, 9'h0DD};
    // PW written with byte_wr_n = 4'b1010: lanes 0 and 2 from PW, 1 and 3 from D5
    localparam logic [35:0] MG  = {9'h011, 9'h0BB, 9'h033, 9'h0DD};
    localparam logic [35:0] D7  = 36'h7A5C3E1F0;
    localparam logic [35:0] D9  = 36'h9192A3B4C;
    localparam logic [35:0] GB  = 36'hFFFFFFFFF;
    localparam logic [35:0] B0  = 36'hB00000001;
    localparam logic [35:0] B1  = 36'hB10000002;
    localparam logic [35:0] B2  = 36'hB20000003;
    localparam logic [35:0] B3  = 36'hB30000004;

    // {kind[1:0], addr[5:0], byte_wr_n[3:0], wdata[35:0], exp_oe, exp_data[35:0]}
    localparam int VW = 85;
    localparam int NV = 12;
    localparam logic [VW-1:0] VEC [NV] = '{
        {2'd2, 6'd5, 4'b0000, 36'd0, 1'b0, 36'd0},   // R4 write 5
        {2'd2, 6'd6, 4'b0000, 36'd0, 1'b0, 36'd0},   // R4 write 6
        {2'd1, 6'd5, 4'b0000, D5,    1'b0, 36'd0},   // R2 data for 5, R8 no drive
        {2'd1, 6'd6, 4'b0000, D6,    1'b0, 36'd0},   // R2 data for 6
        {2'd2, 6'd5, 4'b1010, 36'd0, 1'b1, D5},      // R1 read 5
        {2'd1, 6'd5, 4'b0000, 36'd0, 1'b1, D6},      // R1 read 6
        {2'd0, 6'd0, 4'b0000, PW,    1'b0, 36'd0},   // R3 partial data, R8
        {2'd0, 6'd0, 4'b0000, 36'd0, 1'b1, MG},      // R5 forwarded merge
        {2'd1, 6'd5, 4'b0000, 36'd0, 1'b0, 36'd0},   // R7 deselect phase
        {2'd0, 6'd0, 4'b0000, 36'd0, 1'b0, 36'd0},
        {2'd0, 6'd0, 4'b0000, 36'd0, 1'b1, MG},      // R3 committed lanes
        {2'd0, 6'd0, 4'b0000, 36'd0, 1'b0, 36'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_en = 1'b1;
    logic        sel_a_n = 1'b1;
    logic        sel_b = 1'b1;
    logic        sel_c_n = 1'b0;
    logic        adv_ld = 1'b0;
    logic        wr_n = 1'b1;
    logic [3:0]  byte_wr_n = 4'hF;
    logic        burst_ilv = 1'b0;
    logic        out_en_n = 1'b0;
    logic [5:0]  addr = '0;
    logic [35:0] wdata = '0;
    logic [35:0] rdata;
    logic        rdata_oe;

    logic [2:0]  ce_bad = 3'b000;
    int          n_chk = 0;
    int          n_err = 0;
    logic        done = 1'b0;

    always #4 clk = ~clk;

    ztsram_core u_dut (
        .clk       (clk),
        .rst       (rst),
        .clk_en    (clk_en),
        .sel_a_n   (sel_a_n),
        .sel_b     (sel_b),
        .sel_c_n   (sel_c_n),
        .adv_ld    (adv_ld),
        .wr_n      (wr_n),
        .byte_wr_n (byte_wr_n),
        .burst_ilv (burst_ilv),
        .out_en_n  (out_en_n),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .rdata_oe  (rdata_oe)
    );

    // drive one cycle of inputs, let one rising edge pass, return at the falling edge
    task automatic cyc(input int kind, input logic [5:0] a, input logic [3:0] bwn,
                       input logic [35:0] wd);
        if (kind == K_ADV) begin
            adv_ld  = 1'b1;
            wr_n    = 1'b0;   // ignored while advancing
            sel_a_n = 1'b1;   // ignored while advancing
            sel_b   = 1'b0;
            sel_c_n = 1'b1;
        end else begin
            adv_ld  = 1'b0;
            wr_n    = (kind != K_WR);
            sel_a_n = (kind == K_DES) | ce_bad[0];
            sel_b   = !ce_bad[1];
            sel_c_n = ce_bad[2];
        end
        addr      = a;
        byte_wr_n = bwn;
        wdata     = wd;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic exp_oe, input logic [35:0] exp_d);
        n_chk++;
        if (rdata_oe !== exp_oe || (exp_oe && rdata !== exp_d)) begin
            n_err++;
            $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h",
                     req, rdata_oe, rdata, exp_oe, exp_d);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) cyc(K_DES, 6'd0, 4'hF, 36'd0);
        rst = 1'b0;
        chk("R12 idle after reset", 1'b0, 36'd0);

        // vector table: back-to-back mix, lanes, forwarding, deselect
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            cyc(int'(v[84:83]), v[82:77], v[76:73], v[72:37]);
            chk($sformatf("R1/R2/R3/R4/R5 vector %0d", i), v[36], v[35:0]);
        end

        // R6 stall during a read
        cyc(K_RD, 6'd5, 4'hF, 36'd0);
        clk_en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            cyc(K_RD, 6'd6, 4'h0, GB);
            chk("R6 stalled read pending", 1'b0, 36'd0);
        end
        clk_en = 1'b1;
        cyc(K_DES, 6'd0, 4'hF, 36'd0);
        chk("R6 one enabled edge only", 1'b0, 36'd0);
        cyc(K_DES, 6'd0, 4'hF, 36'd0);
        chk("R1 read after stall", 1'b1, MG);
        clk_en = 1'b0;
        cyc(K_DES, 6'd0, 4'hF, 36'd0);
        chk("R6 output held in stall", 1'b1, MG);
        out_en_n = 1'b1;
        #1;
        chk("R8 output enable forces off", 1'b0, 36'd0);
        out_en_n = 1'b0;
        #1;
        chk("R8 output enable restored", 1'b1, MG);
        clk_en = 1'b1;

        // R6 stall during a write: data sampled only at the second enabled edge
        cyc(K_WR, 6'd7, 4'h0, 36'd0);
        clk_en = 1'b0;
        cyc(K_DES, 6'd0, 4'hF, GB);
        clk_en = 1'b1;
        cyc(K_DES, 6'd0, 4'hF, GB);
        cyc(K_DES, 6'd0, 4'hF, D7);
        chk("R8 no drive in write phase", 1'b0, 36'd0);
        cyc(K_RD, 6'd7, 4'hF, GB);
        cyc(K_DES, 6'd0, 4'hF, GB);
        cyc(K_DES, 6'd0, 4'hF, GB);
        chk("R6 write sampled after stall", 1'b1, D7);

        // R7 each chip enable alone deselects a write and a read
        for (int k = 0; k < 3; k++) begin
            ce_bad = 3'b001 << k;
            cyc(K_WR, 6'd5, 4'h0, 36'd0);
            cyc(K_RD, 6'd5, 4'h0, 36'd0);
            ce_bad = 3'b000;
            cyc(K_DES, 6'd0, 4'hF, GB);
            chk("R7 deselected write not driven", 1'b0, 36'd0);
            cyc(K_DES, 6'd0, 4'hF, GB);
            chk("R7 deselected read not driven", 1'b0, 36'd0);
        end
        cyc(K_RD, 6'd5, 4'hF, 36'd0);
        cyc(K_DES, 6'd0, 4'hF, 36'd0);
        cyc(K_DES, 6'd0, 4'hF, 36'd0);
        chk("R7 array untouched by deselects", 1'b1, MG);

        // R9 linear write burst from 0x12: 0x12,0x13,0x10,0x11
        burst_ilv = 1'b0;
        cyc(K_WR, 6'h12, 4'h0, 36'd0);
        cyc(K_ADV, 6'h3F, 4'h0, 36'd0);
        cyc(K_ADV, 6'h3F, 4'h0, B0);
        chk("R8 burst write phase", 1'b0, 36'd0);
        cyc(K_ADV, 6'h3F, 4'h0, B1);
        cyc(K_DES, 6'd0, 4'hF, B2);
        cyc(K_DES, 6'd0, 4'hF, B3);
        chk("R8 burst write last phase", 1'b0, 36'd0);
        cyc(K_RD, 6'h10, 4'hF, 36'd0);
        cyc(K_RD, 6'h11, 4'hF, 36'd0);
        cyc(K_RD, 6'h12, 4'hF, 36'd0);
        chk("R9 linear wrap to 0x10", 1'b1, B2);
        cyc(K_RD, 6'h13, 4'hF, 36'd0);
        chk("R9 linear step 3 at 0x11", 1'b1, B3);
        cyc(K_DES, 6'd0, 4'hF, 36'd0);
        chk("R9 linear start 0x12", 1'b1, B0);
        cyc(K_DES, 6'd0, 4'hF, 36'd0);
        chk("R9 linear step 1 at 0x13", 1'b1, B1);

        // R10 interleaved read burst from 0x13 (3,2,1,0); R11 order flipped mid-burst
        burst_ilv = 1'b1;
        cyc(K_RD, 6'h13, 4'hF, 36'd0);
        burst_ilv = 1'b0;
        cyc(K_ADV, 6'h00, 4'hF, 36'd0);
        cyc(K_ADV, 6'h00, 4'hF, 36'd0);
        chk("R10 interleaved step 0", 1'b1, B1);
        cyc(K_ADV, 6'h00, 4'hF, 36'd0);
        chk("R10 interleaved step 1", 1'b1, B0);
        cyc(K_DES, 6'd0, 4'hF, 36'd0);
        chk("R11 interleaved kept at step 2", 1'b1, B3);
        cyc(K_DES, 6'd0, 4'hF, 36'd0);
        chk("R11 interleaved kept at step 3", 1'b1, B2);

        // R9 linear read burst from 0x11 (1,2,3,0); R11 order flipped mid-burst
        burst_ilv = 1'b0;
        cyc(K_RD, 6'h11, 4'hF, 36'd0);
        burst_ilv = 1'b1;
        cyc(K_ADV, 6'h2A, 4'hF, 36'd0);
        cyc(K_ADV, 6'h2A, 4'hF, 36'd0);
        chk("R9 linear read step 0", 1'b1, B3);
        cyc(K_ADV, 6'h2A, 4'hF, 36'd0);
        chk("R9 linear read step 1", 1'b1, B0);
        cyc(K_DES, 6'd0, 4'hF, 36'd0);
        chk("R11 linear kept at step 2", 1'b1, B1);
        cyc(K_DES, 6'd0, 4'hF, 36'd0);
        chk("R11 linear kept at step 3", 1'b1, B2);
        burst_ilv = 1'b0;

        // R12 reset cancels a write in flight, array survives
        cyc(K_WR, 6'd9, 4'h0, 36'd0);
        cyc(K_DES, 6'd0, 4'hF, 36'd0);
        cyc(K_DES, 6'd0, 4'hF, D9);
        cyc(K_RD, 6'd9, 4'hF, 36'd0);
        cyc(K_WR, 6'd9, 4'h0, 36'd0);
        rst = 1'b1;
        cyc(K_DES, 6'd0, 4'hF, GB);
        rst = 1'b0;
        chk("R12 read in flight cancelled", 1'b0, 36'd0);
        cyc(K_DES, 6'd0, 4'hF, GB);
        chk("R12 no drive after reset", 1'b0, 36'd0);
        cyc(K_RD, 6'd9, 4'hF, GB);
        cyc(K_DES, 6'd0, 4'hF, GB);
        cyc(K_DES, 6'd0, 4'hF, GB);
        chk("R12 cancelled write left array intact", 1'b1, D9);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule